// File: doc/BRIEF.md
# Parallel Bus Transaction Sequencer

This block is the host-side master of a simple parallel peripheral bus. An internal client hands it one read or one write at a time through a valid/ready request port. The block turns each request into a short sequence of bus phases on a shared 32-wire pad bus. An address field sits in the upper part of the bus and ends at bit 27. A data field sits in the low bits. A read strobe and a write strobe tell the peripheral what kind of phase is running, and read data is captured from the pad inputs.

Static configuration inputs choose the address width, the data width, single- or split-phase writes, and whether strobes are driven. The address and the data share pads, so a wide address leaves less room for data. The block checks every combination and refuses requests while the setting is illegal. When the ready input is enabled, the peripheral can stretch any phase.

Top module: `pbus_sequencer`

## Requirements
- R1: An accepted read takes two phases. The first phase drives the address field with `pad_oe` high and `rd_strobe` high (when strobes are in use). In the second phase `rd_strobe` and `pad_oe` are low. At the edge that ends the second phase, `pad_in` is sampled into `rd_data` and `done` rises.
- R2: With `cfg_addr_sel`=0 (no address), a read still asserts `rd_strobe` in its first phase, drives all pads low, and captures data at the end of the second phase.
- R3: With `cfg_wr_two`=0, a write is one phase: the address and data fields are driven together, with `wr_strobe` high when strobes are in use, and `done` follows that phase.
- R4: With `cfg_wr_two`=1, a write is two phases. The first phase drives only the address field with `wr_strobe` high. The second drives only the data field with `wr_strobe` low and `pad_oe` high.
- R5: With `cfg_strobe_en`, `cfg_rd_split` and `cfg_wr_two` all 0, neither strobe is ever asserted, but the phases and pad contents are unchanged.
- R6: Setting `cfg_rd_split` or `cfg_wr_two` turns strobes on whatever `cfg_strobe_en` is.
- R7: `cfg_addr_sel` codes 0,1,2,3 mean no address, 4, 12 and 20 bits. The low address bits are placed at pads [27:24], [27:16] or [27:8] respectively, and higher request address bits are dropped.
- R8: `cfg_data_sel` codes 0,1,2,3 mean 8, 16, 24 and 32 data bits, on pads [N-1:0]. Write data bits above N are dropped, `rd_data` bits above N read as 0, and pads outside both fields are driven 0.
- R9: With `cfg_ready_en`=1 and `periph_ready` low, the current phase holds: pads, strobes and state do not change and `done` stays low. With `cfg_ready_en`=0, `periph_ready` is ignored.
- R10: The configuration is illegal when an address is used and the data width exceeds 28 minus the address width, or when 32-bit data is chosen with neither `cfg_rd_split` nor `cfg_wr_two`. One cycle after such a setting, `config_error` is high and `req_ready` is low, and no request is started.
- R11: `req_ready` is high only while idle and legal. `done` is a single-cycle pulse per transaction, and `rd_data` holds its value until the next read completes.
- R12: While `rst` is high, all strobes, `pad_oe`, `pad_out`, `done` and `req_ready` are 0, and `config_error` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_sel | input | 2 | Address width code (0 none, 1 4-bit, 2 12-bit, 3 20-bit) |
| cfg_data_sel | input | 2 | Data width code (0 8-bit, 1 16-bit, 2 24-bit, 3 32-bit) |
| cfg_strobe_en | input | 1 | Drive RD/WR strobes |
| cfg_rd_split | input | 1 | Split-read mode, forces strobes on |
| cfg_wr_two | input | 1 | Two-phase writes, forces strobes on |
| cfg_ready_en | input | 1 | Honour the peripheral ready input |
| config_error | output | 1 | Illegal width/mode combination |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when valid and ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Captured read data |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| pad_out | output | 32 | Value driven on the pad bus |
| pad_oe | output | 1 | Pad bus output enable |
| pad_in | input | 32 | Value sampled from the pad bus |
| periph_ready | input | 1 | Peripheral ready |

## Verification
The bench stretches both read phases with ready held low. A design that gated only one phase would raise `done` early or drop the strobe mid-stall. It runs each address width with request bits above the field set, so an unmasked address would leak into neighbouring pads or into the data lanes. It drives full-width values onto `pad_in`, so a missing read mask would show stray high bits. It also runs illegal width pairs and the 32-bit no-split case, where a weak checker would still start a bus cycle. Strobe forcing is tested with the enable off, which exposes a design that lets the enable win over split mode.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RD_ADDR = 3'd1,
    PH_RD_CAP  = 3'd2,
    PH_WR_ONE  = 3'd3,
    PH_WR_ADDR = 3'd4,
    PH_WR_DATA = 3'd5
  } phase_t;

  // address width in bits for a select code
  function automatic int addr_bits(input logic [1:0] sel);
    case (sel)
      2'd1:    return 4;
      2'd2:    return 12;
      2'd3:    return 20;
      default: return 0;
    endcase
  endfunction

  // data width in bits for a select code
  function automatic int data_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/pbus_cfg_check.sv
module pbus_cfg_check
  import pbus_pkg::*;
#(
  parameter int ADDR_TOP = 28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr_sel,
  input  logic [1:0] data_sel,
  input  logic       strobe_en,
  input  logic       rd_split,
  input  logic       wr_two,
  output logic       cfg_err,
  output logic       strobes_on
);

  int   aw;
  int   dw;
  logic overlap;
  logic wide_no_split;
  logic bad;

  always_comb begin
    aw            = addr_bits(addr_sel);
    dw            = data_bits(data_sel);
    overlap       = (aw != 0) && (dw > (ADDR_TOP - aw));
    wide_no_split = (dw == 32) && !rd_split && !wr_two;
    bad           = overlap || wide_no_split;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err    <= 1'b1;
      strobes_on <= 1'b0;
    end else begin
      cfg_err    <= bad;
      strobes_on <= strobe_en | rd_split | wr_two;
    end
  end

  AST_WIDE_NEEDS_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (data_sel == 2'd3 && !rd_split && !wr_two) |=> cfg_err); // R10

  AST_SPLIT_FORCES_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rd_split || wr_two) |=> strobes_on); // R6

endmodule

// File: rtl/pbus_lane_map.sv
module pbus_lane_map
  import pbus_pkg::*;
#(
  parameter int PAD_W    = 32,
  parameter int ADDR_W   = 20,
  parameter int ADDR_TOP = 28
) (
  input  logic [1:0]        addr_sel,
  input  logic [1:0]        data_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAD_W-1:0]  wdata,
  input  logic [PAD_W-1:0]  pad_in,
  output logic [PAD_W-1:0]  addr_field,
  output logic [PAD_W-1:0]  data_field,
  output logic [PAD_W-1:0]  rdata
);

  localparam int EXT_W = PAD_W - ADDR_W;

  int               aw;
  int               dw;
  int               lo;
  logic [PAD_W-1:0] amask;
  logic [PAD_W-1:0] dmask;
  logic [PAD_W-1:0] addr_shift;

  always_comb begin
    aw = addr_bits(addr_sel);
    dw = data_bits(data_sel);
    lo = ADDR_TOP - aw;
  end

  for (genvar i = 0; i < PAD_W; i++) begin : g_lane
    assign amask[i] = (aw != 0) && (i >= lo) && (i < ADDR_TOP);
    assign dmask[i] = (i < dw);
  end

  always_comb begin
    addr_shift = {{EXT_W{1'b0}}, addr} << lo;
    addr_field = addr_shift & amask;
    data_field = wdata & dmask;
    rdata      = pad_in & dmask;
  end

endmodule

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
  import pbus_pkg::*;
#(
  parameter int PAD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [PAD_W-1:0] addr_field,
  input  logic [PAD_W-1:0] data_field,
  input  logic [PAD_W-1:0] cap_data,
  input  logic             cfg_err,
  input  logic             strobes_on,
  input  logic             wr_two,
  input  logic             ready_ok,
  output logic             req_ready,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic [PAD_W-1:0] pad_out,
  output logic             pad_oe,
  output logic             done,
  output logic [PAD_W-1:0] rd_data
);

  phase_t           state;
  logic [PAD_W-1:0] data_hold;
  logic             idle;

  assign idle      = (state == PH_IDLE);
  assign req_ready = idle && !cfg_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      pad_out   <= '0;
      pad_oe    <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      data_hold <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (req_valid && !cfg_err) begin
            pad_oe <= 1'b1;
            if (!req_write) begin
              state     <= PH_RD_ADDR;
              rd_strobe <= strobes_on;
              pad_out   <= addr_field;
            end else if (wr_two) begin
              state     <= PH_WR_ADDR;
              wr_strobe <= 1'b1;
              pad_out   <= addr_field;
              data_hold <= data_field;
            end else begin
              state     <= PH_WR_ONE;
              wr_strobe <= strobes_on;
              pad_out   <= addr_field | data_field;
            end
          end
        end
        PH_RD_ADDR: begin
          if (ready_ok) begin
            state     <= PH_RD_CAP;
            rd_strobe <= 1'b0;
            pad_out   <= '0;
            pad_oe    <= 1'b0;
          end
        end
        PH_RD_CAP: begin
          if (ready_ok) begin
            state   <= PH_IDLE;
            rd_data <= cap_data;
            done    <= 1'b1;
          end
        end
        PH_WR_ADDR: begin
          if (ready_ok) begin
            state     <= PH_WR_DATA;
            wr_strobe <= 1'b0;
            pad_out   <= data_hold;
          end
        end
        PH_WR_ONE, PH_WR_DATA: begin
          if (ready_ok) begin
            state     <= PH_IDLE;
            wr_strobe <= 1'b0;
            pad_out   <= '0;
            pad_oe    <= 1'b0;
            done      <= 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!idle && !ready_ok) |=> ($stable(pad_out) && $stable(rd_strobe) && $stable(wr_strobe) && !done)); // R9

  AST_RD_THEN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && ready_ok) |=> (!rd_strobe && !pad_oe && !done)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
    (idle && cfg_err) |=> (!rd_strobe && !wr_strobe && !pad_oe)); // R10

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe)); // R11

endmodule

// File: rtl/pbus_sequencer.sv
module pbus_sequencer
  import pbus_pkg::*;
#(
  parameter int PAD_W    = 32,
  parameter int ADDR_W   = 20,
  parameter int ADDR_TOP = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_addr_sel,
  input  logic [1:0]        cfg_data_sel,
  input  logic              cfg_strobe_en,
  input  logic              cfg_rd_split,
  input  logic              cfg_wr_two,
  input  logic              cfg_ready_en,
  output logic              config_error,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PAD_W-1:0]  req_wdata,
  output logic              done,
  output logic [PAD_W-1:0]  rd_data,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [PAD_W-1:0]  pad_out,
  output logic              pad_oe,
  input  logic [PAD_W-1:0]  pad_in,
  input  logic              periph_ready
);

  logic             strobes_on;
  logic             ready_ok;
  logic [PAD_W-1:0] addr_field;
  logic [PAD_W-1:0] data_field;
  logic [PAD_W-1:0] cap_data;

  assign ready_ok = !cfg_ready_en || periph_ready;

  pbus_cfg_check #(.ADDR_TOP(ADDR_TOP)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .addr_sel   (cfg_addr_sel),
    .data_sel   (cfg_data_sel),
    .strobe_en  (cfg_strobe_en),
    .rd_split   (cfg_rd_split),
    .wr_two     (cfg_wr_two),
    .cfg_err    (config_error),
    .strobes_on (strobes_on)
  );

  pbus_lane_map #(.PAD_W(PAD_W), .ADDR_W(ADDR_W), .ADDR_TOP(ADDR_TOP)) u_lanes (
    .addr_sel   (cfg_addr_sel),
    .data_sel   (cfg_data_sel),
    .addr       (req_addr),
    .wdata      (req_wdata),
    .pad_in     (pad_in),
    .addr_field (addr_field),
    .data_field (data_field),
    .rdata      (cap_data)
  );

  pbus_phase_fsm #(.PAD_W(PAD_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .addr_field (addr_field),
    .data_field (data_field),
    .cap_data   (cap_data),
    .cfg_err    (config_error),
    .strobes_on (strobes_on),
    .wr_two     (cfg_wr_two),
    .ready_ok   (ready_ok),
    .req_ready  (req_ready),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .done       (done),
    .rd_data    (rd_data)
  );

  AST_NO_READY_WHEN_ERR: assert property (@(posedge clk) disable iff (rst)
    config_error |-> !req_ready); // R10

endmodule

// File: tb/test_pbus_sequencer.sv
`timescale 1ns/1ps
module test_pbus_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_addr_sel = 2'd0;
  logic [1:0]  cfg_data_sel = 2'd0;
  logic        cfg_strobe_en = 1'b1;
  logic        cfg_rd_split = 1'b0;
  logic        cfg_wr_two = 1'b0;
  logic        cfg_ready_en = 1'b0;
  logic        config_error;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rd_data;
  logic        rd_strobe;
  logic        wr_strobe;
  logic [31:0] pad_out;
  logic        pad_oe;
  logic [31:0] pad_in = '0;
  logic        periph_ready = 1'b1;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pbus_sequencer i_pbus_sequencer (
    .clk(clk), .rst(rst),
    .cfg_addr_sel(cfg_addr_sel), .cfg_data_sel(cfg_data_sel),
    .cfg_strobe_en(cfg_strobe_en), .cfg_rd_split(cfg_rd_split),
    .cfg_wr_two(cfg_wr_two), .cfg_ready_en(cfg_ready_en),
    .config_error(config_error),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
    .periph_ready(periph_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] a, input logic [1:0] d, input logic se,
                         input logic rs, input logic wt, input logic re);
    @(negedge clk);
    cfg_addr_sel = a; cfg_data_sel = d; cfg_strobe_en = se;
    cfg_rd_split = rs; cfg_wr_two = wt; cfg_ready_en = re;
    @(negedge clk);
    @(negedge clk);
  endtask

  // issue a request at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic wr, input logic [19:0] a, input logic [31:0] d);
    chk("R11 req_ready idle", {31'b0, req_ready}, 32'd1);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [19:0] a, input logic [31:0] pin,
                         input logic [31:0] exp_pad, input logic exp_rd, input logic [31:0] exp_data);
    pad_in = pin;
    issue(1'b0, a, 32'h0);
    chk({tag, " phase1 pad"}, pad_out, exp_pad);
    chk({tag, " phase1 rd"}, {31'b0, rd_strobe}, {31'b0, exp_rd});
    chk({tag, " phase1 oe"}, {31'b0, pad_oe}, 32'd1);
    chk("R11 busy not ready", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk({tag, " phase2 rd/oe/done"}, {29'b0, rd_strobe, pad_oe, done}, 32'd0);
    @(negedge clk);
    chk({tag, " done"}, {31'b0, done}, 32'd1);
    chk({tag, " rd_data"}, rd_data, exp_data);
    pad_in = 32'h0;
    @(negedge clk);
    chk("R11 done pulse", {31'b0, done}, 32'd0);
    chk("R11 rd_data held", rd_data, exp_data);
  endtask

  task automatic do_write1(input string tag, input logic [19:0] a, input logic [31:0] d,
                           input logic [31:0] exp_pad, input logic exp_wr);
    issue(1'b1, a, d);
    chk({tag, " pad"}, pad_out, exp_pad);
    chk({tag, " wr"}, {31'b0, wr_strobe}, {31'b0, exp_wr});
    chk({tag, " rd low"}, {31'b0, rd_strobe}, 32'd0);
    @(negedge clk);
    chk({tag, " done"}, {31'b0, done}, 32'd1);
    chk({tag, " idle pads"}, {pad_out[31:1], pad_oe}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 outputs in reset", {27'b0, rd_strobe, wr_strobe, pad_oe, done, req_ready}, 32'd0);
    chk("R12 pad_out in reset", pad_out, 32'd0);
    chk("R12 config_error in reset", {31'b0, config_error}, 32'd1);
  endtask

  task automatic t_read_addr4;
    set_cfg(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 legal 4+16", {31'b0, config_error}, 32'd0);
    // R1 R7 R8: addr bits [3:0]=5 at pads [27:24], 16-bit capture
    do_read("R1 R7 R8 read a4", 20'h3A5, 32'hFFFF_1234, 32'h0500_0000, 1'b1, 32'h0000_1234);
  endtask

  task automatic t_read_noaddr;
    set_cfg(2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 legal 32 split", {31'b0, config_error}, 32'd0);
    do_read("R2 R6 read no addr", 20'hFFFFF, 32'hDEAD_BEEF, 32'h0, 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_one;
    set_cfg(2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R3 R7 R8: 12-bit addr at [27:16], 16-bit data low
    do_write1("R3 R7 R8 write 1-phase", 20'hABCDE, 32'h9876_5432, 32'h0CDE_5432, 1'b1);
  endtask

  task automatic t_write_two;
    set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    issue(1'b1, 20'h12345, 32'h0000_01FF);
    chk("R4 R7 addr phase pad", pad_out, 32'h0123_4500);
    chk("R6 wr forced on", {31'b0, wr_strobe}, 32'd1);
    @(negedge clk);
    chk("R4 R8 data phase pad", pad_out, 32'h0000_00FF);
    chk("R4 data phase wr/oe/done", {29'b0, wr_strobe, pad_oe, done}, 32'd2);
    @(negedge clk);
    chk("R4 done", {31'b0, done}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_no_strobe;
    set_cfg(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_write1("R5 write no strobe", 20'h00007, 32'h1234_56A5, 32'h0700_00A5, 1'b0);
    do_read("R5 read no strobe", 20'h00007, 32'h1111_11C3, 32'h0700_0000, 1'b0, 32'h0000_00C3);
  endtask

  task automatic t_stall;
    set_cfg(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    periph_ready = 1'b0;
    pad_in = 32'h0000_BEEF;
    issue(1'b0, 20'h2, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 stall addr phase", {29'b0, rd_strobe, pad_oe, done}, 32'd6);
      chk("R9 stall addr pad", pad_out, 32'h0200_0000);
    end
    periph_ready = 1'b1;
    @(negedge clk);
    periph_ready = 1'b0;
    chk("R9 capture phase entered", {29'b0, rd_strobe, pad_oe, done}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R9 stall capture phase", {31'b0, done}, 32'd0);
    end
    periph_ready = 1'b1;
    @(negedge clk);
    chk("R9 done after stall", {31'b0, done}, 32'd1);
    chk("R9 data after stall", rd_data, 32'h0000_BEEF);
    @(negedge clk);
    // ready disabled: periph_ready low is ignored
    set_cfg(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    periph_ready = 1'b0;
    do_write1("R9 ready ignored", 20'h1, 32'h0000_00AA, 32'h0100_00AA, 1'b1);
    periph_ready = 1'b1;
  endtask

  task automatic t_cfg_err;
    set_cfg(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 12+24 error", {30'b0, config_error, req_ready}, 32'd2);
    req_valid = 1'b1; req_write = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no start on error", {29'b0, rd_strobe, wr_strobe, pad_oe}, 32'd0);
    end
    req_valid = 1'b0;
    set_cfg(2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 20+16 error", {31'b0, config_error}, 32'd1);
    set_cfg(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 32 no split error", {31'b0, config_error}, 32'd1);
    set_cfg(2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10 32 with wr_two legal", {30'b0, config_error, req_ready}, 32'd1);
    set_cfg(2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10 20+8 legal", {31'b0, config_error}, 32'd0);
  endtask

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_read_addr4();
    t_read_noaddr();
    t_write_one();
    t_write_two();
    t_no_strobe();
    t_stall();
    t_cfg_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule